// File: doc/BRIEF.md
# Ethernet Controller Register Front End with Interrupt Logic

This unit is the host-facing register front end of a descriptor-ring Ethernet controller. The host first loads an 8-bit index into a pointer register. It then reaches one of two register banks through two data ports: the control/status bank and the bus configuration bank. Both ports are selected by the index held in the pointer.

The unit keeps four registers with special handling in the control/status bank:
- the main control word (index 0),
- the interrupt mask word (index 3),
- the ring-size word (index 6),
- the mode word (index 15).

Every other index within the bank depth is plain read/write storage.

The main control word takes single-cycle event pulses from the receive engine, the transmit engine and the init sequencer. From that word the unit derives the receive and transmit enables, the summary error bit and the interrupt flag, and it drives a level interrupt request. A write that starts an init sequence, and a write that stops the controller, each produce a one-cycle pulse for the neighbouring engines. The receive and transmit ring sizes are given as power-of-two exponents and are decoded into entry counts.

Top module: `ether_csr_frontend`

## Requirements
- R1: A write to bus offset 0x14 loads the low 8 bits of the write data into the register pointer. A read of offset 0x14 returns the pointer, zero-extended to 16 bits.
- R2: Offset 0x10 reaches the control/status bank and offset 0x1C reaches the configuration bank, both at the index held in the pointer. The two banks are separate. A plain index (any index except 0, 3, 6 and 15 in the control/status bank) reads back the last value written to it. Any bus offset other than 0x10, 0x14 and 0x1C reads as 0.
- R3: A control-word write with bit 2 (stop) set has priority over everything else:
  - the control word becomes exactly 0x0004;
  - init, start and any event pulse in that same cycle are ignored;
  - `ring_clr` is high for one cycle, in the cycle after the write.
- R4: Event input `evt_set[i]` sets control-word bit 8+i. The bit meanings are:
  - i=0: init done;
  - i=1: transmit interrupt;
  - i=2: receive interrupt;
  - i=3: memory error;
  - i=4: missed frame;
  - i=5: collision;
  - i=6: transmit timeout.

  In a non-stop control-word write, a 1 in any of bits 14..8 clears that bit and a 0 leaves it as it was. An event that arrives in the same cycle as the clear wins.
- R5: Every non-stop control-word write loads bit 6 (interrupt enable) from the written data.
- R6: A non-stop control-word write with bit 0 set sets bit 0 (init) and clears bit 2. `init_req` is high for one cycle, in the cycle after the write.
- R7: A non-stop control-word write with bit 1 set sets bit 1 (start) and clears bit 2.
- R8: Receive-on (`rx_on`, read as control-word bit 5) is start AND NOT mode-word bit 0. Transmit-on (`tx_on`, read as bit 4) is start AND NOT mode-word bit 1.
- R9: The interrupt flag (control-word bit 7) is 1 when any of bits 14..8 is set while the same bit of the mask word is 0. `irq` is the flag AND bit 6.
- R10: Control-word bit 15 reads as the OR of bits 14..11. Writing it has no effect.
- R11: Index 6 holds the receive ring exponent in bits 11..8 and the transmit ring exponent in bits 15..12. A read of index 6 returns these two fields, with bits 7..0 reading 0. Each ring length output is 2 to the power of its exponent, capped at 512.
- R12: After reset, the pointer is 0 and the control word reads 0x0004. The mask word, the mode word, the ring-size word and all plain storage are 0, so `irq`, `rx_on` and `tx_on` are 0 and both ring lengths are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the unit |
| bus_en | input | 1 | Host access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Host byte offset (0x10, 0x14, 0x1C decoded) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, combinational from offset and state |
| evt_set | input | 7 | Single-cycle event pulses, bit i sets control-word bit 8+i |
| irq | output | 1 | Level interrupt request |
| rx_on | output | 1 | Receive engine enable |
| tx_on | output | 1 | Transmit engine enable |
| init_req | output | 1 | One-cycle pulse: begin init-block fetch |
| ring_clr | output | 1 | One-cycle pulse: reset ring positions to 0 |
| rx_ring_len | output | 10 | Receive ring entry count |
| tx_ring_len | output | 10 | Transmit ring entry count |

## Verification
The assertions assume that each event input is a pulse asserted only while the engine has something new to report. They also assume that the host leaves the bus idle while reset is held, because the internal reset is released two cycles after `rst_n` rises. The stimulus drives every access for exactly one cycle and changes inputs shortly after a rising edge. It fires events alone, together with a clearing write, and together with a stop write, so the priority between clears, event sets and stop is exercised with both orderings.

// File: rtl/efe_pkg.sv
`timescale 1ns/1ps
package efe_pkg;
  localparam int WORD_W  = 16;
  localparam int PTR_W   = 8;
  localparam int EVT_W   = 7;
  localparam int EVT_LSB = 8;
  localparam int ERR_LO  = 11;
  localparam int ERR_HI  = 14;

  localparam int BIT_ERR  = 15;
  localparam int BIT_FLAG = 7;
  localparam int BIT_IEN  = 6;
  localparam int BIT_RXON = 5;
  localparam int BIT_TXON = 4;
  localparam int BIT_STOP = 2;
  localparam int BIT_STRT = 1;
  localparam int BIT_INIT = 0;

  localparam int MODE_NO_RX = 0;
  localparam int MODE_NO_TX = 1;

  localparam logic [WORD_W-1:0] CLR1_MASK = 16'h7F00;
  localparam logic [WORD_W-1:0] STOP_WORD = 16'h0004;
  localparam logic [WORD_W-1:0] HELD_MASK = 16'h7F47;

  localparam logic [PTR_W-1:0] IX_CTRL = 8'd0;
  localparam logic [PTR_W-1:0] IX_MASK = 8'd3;
  localparam logic [PTR_W-1:0] IX_RLEN = 8'd6;
  localparam logic [PTR_W-1:0] IX_MODE = 8'd15;

  typedef enum logic [1:0] {SEL_NONE, SEL_PTR, SEL_CSR, SEL_BCR} port_sel_e;

  function automatic port_sel_e port_of(input logic [7:0] ofs);
    case (ofs)
      8'h10:   return SEL_CSR;
      8'h14:   return SEL_PTR;
      8'h1C:   return SEL_BCR;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/efe_reg_bank.sv
`timescale 1ns/1ps
module efe_reg_bank #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic          hit;
  logic [AW-1:0] slot;

  assign hit  = (int'(idx) < DEPTH);
  assign slot = idx[AW-1:0];

  always_comb begin
    mem_d = mem_q;
    if (we && hit) mem_d[slot] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  assign rdata = hit ? mem_q[slot] : '0;

  assert_store_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit) |=> (mem_q[$past(slot)] == $past(wdata)));
endmodule

// File: rtl/efe_ctrl_word.sv
`timescale 1ns/1ps
module efe_ctrl_word
  import efe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              init_pulse_q,
  output logic              clr_pulse_q
);
  logic [WORD_W-1:0] ctrl_d;
  logic [WORD_W-1:0] evt_word;
  logic              init_pulse_d;
  logic              clr_pulse_d;
  logic              stop_req;

  assign stop_req = wr_en & wdata[BIT_STOP];
  assign evt_word = {1'b0, evt, {EVT_LSB{1'b0}}};

  always_comb begin
    ctrl_d       = ctrl_q;
    init_pulse_d = 1'b0;
    clr_pulse_d  = 1'b0;
    if (stop_req) begin
      ctrl_d      = STOP_WORD;
      clr_pulse_d = 1'b1;
    end else begin
      if (wr_en) begin
        ctrl_d          = ctrl_d & ~(wdata & CLR1_MASK);
        ctrl_d[BIT_IEN] = wdata[BIT_IEN];
        if (wdata[BIT_INIT]) begin
          ctrl_d[BIT_INIT] = 1'b1;
          ctrl_d[BIT_STOP] = 1'b0;
          init_pulse_d     = 1'b1;
        end
        if (wdata[BIT_STRT]) begin
          ctrl_d[BIT_STRT] = 1'b1;
          ctrl_d[BIT_STOP] = 1'b0;
        end
      end
      ctrl_d = (ctrl_d | evt_word) & HELD_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= STOP_WORD;
      init_pulse_q <= 1'b0;
      clr_pulse_q  <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_d;
      init_pulse_q <= init_pulse_d;
      clr_pulse_q  <= clr_pulse_d;
    end
  end

  assert_stop_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (ctrl_q == STOP_WORD && clr_pulse_q && !init_pulse_q));

  assert_init_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_STOP] && wdata[BIT_INIT]) |=> (init_pulse_q && ctrl_q[BIT_INIT] && !ctrl_q[BIT_STOP]));

  assert_start_clears_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_STOP] && wdata[BIT_STRT]) |=> (ctrl_q[BIT_STRT] && !ctrl_q[BIT_STOP]));

  for (genvar g = 0; g < EVT_W; g++) begin : g_src
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[BIT_STOP] && wdata[EVT_LSB+g] && !evt[g]) |=> !ctrl_q[EVT_LSB+g]);
    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_req && evt[g]) |=> ctrl_q[EVT_LSB+g]);
  end
endmodule

// File: rtl/efe_ring_len.sv
`timescale 1ns/1ps
module efe_ring_len #(
  parameter int LOG2_W   = 4,
  parameter int MAX_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LOG2_W-1:0]   log2_len,
  output logic [MAX_LOG2:0]   len
);
  localparam int LEN_W = MAX_LOG2 + 1;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(1) << MAX_LOG2;

  always_comb begin
    if (int'(log2_len) >= MAX_LOG2) len = CAP;
    else                            len = LEN_W'(1) << log2_len;
  end

  assert_len_pow2_capped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(len) == 1) && (len <= CAP));
endmodule

// File: rtl/ether_csr_frontend.sv
`timescale 1ns/1ps
module ether_csr_frontend
  import efe_pkg::*;
#(
  parameter int CSR_DEPTH     = 32,
  parameter int BCR_DEPTH     = 32,
  parameter int RING_MAX_LOG2 = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [7:0]               bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [EVT_W-1:0]         evt_set,
  output logic                     irq,
  output logic                     rx_on,
  output logic                     tx_on,
  output logic                     init_req,
  output logic                     ring_clr,
  output logic [RING_MAX_LOG2:0]   rx_ring_len,
  output logic [RING_MAX_LOG2:0]   tx_ring_len
);
  localparam int LEN_W   = RING_MAX_LOG2 + 1;
  localparam int RINGS   = 2;
  localparam int RLOG2_W = 4;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // decode
  port_sel_e sel;
  logic      wr_any, wr_ptr, wr_csr, wr_bcr;
  logic      is_ctrl, is_mask, is_rlen, is_mode, is_plain;

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [WORD_W-1:0] mask_q, mask_d;
  logic [WORD_W-1:0] mode_q, mode_d;
  logic [7:0]        rlen_q, rlen_d;

  assign sel      = port_of(bus_addr);
  assign wr_any   = bus_en & bus_we;
  assign wr_ptr   = wr_any & (sel == SEL_PTR);
  assign wr_csr   = wr_any & (sel == SEL_CSR);
  assign wr_bcr   = wr_any & (sel == SEL_BCR);
  assign is_ctrl  = (ptr_q == IX_CTRL);
  assign is_mask  = (ptr_q == IX_MASK);
  assign is_rlen  = (ptr_q == IX_RLEN);
  assign is_mode  = (ptr_q == IX_MODE);
  assign is_plain = ~(is_ctrl | is_mask | is_rlen | is_mode);

  // dedicated registers: next state
  always_comb begin
    ptr_d  = ptr_q;
    mask_d = mask_q;
    mode_d = mode_q;
    rlen_d = rlen_q;
    if (wr_ptr)            ptr_d  = bus_wdata[PTR_W-1:0];
    if (wr_csr && is_mask) mask_d = bus_wdata;
    if (wr_csr && is_mode) mode_d = bus_wdata;
    if (wr_csr && is_rlen) rlen_d = bus_wdata[15:8];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ptr_q  <= '0;
      mask_q <= '0;
      mode_q <= '0;
      rlen_q <= '0;
    end else begin
      if (wr_ptr)            ptr_q  <= ptr_d;
      if (wr_csr && is_mask) mask_q <= mask_d;
      if (wr_csr && is_mode) mode_q <= mode_d;
      if (wr_csr && is_rlen) rlen_q <= rlen_d;
    end
  end

  // control word
  logic [WORD_W-1:0] ctrl_q;

  efe_ctrl_word u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wr_en        (wr_csr & is_ctrl),
    .wdata        (bus_wdata),
    .evt          (evt_set),
    .ctrl_q       (ctrl_q),
    .init_pulse_q (init_req),
    .clr_pulse_q  (ring_clr)
  );

  // storage banks
  logic [WORD_W-1:0] csr_plain_rd, bcr_rd;

  efe_reg_bank #(.DEPTH(CSR_DEPTH), .IDX_W(PTR_W), .DW(WORD_W)) u_csr_bank (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (wr_csr & is_plain),
    .idx   (ptr_q),
    .wdata (bus_wdata),
    .rdata (csr_plain_rd)
  );

  efe_reg_bank #(.DEPTH(BCR_DEPTH), .IDX_W(PTR_W), .DW(WORD_W)) u_bcr_bank (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (wr_bcr),
    .idx   (ptr_q),
    .wdata (bus_wdata),
    .rdata (bcr_rd)
  );

  // ring lengths: index 0 receive, index 1 transmit
  logic [LEN_W-1:0] ring_len [RINGS];

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    efe_ring_len #(.LOG2_W(RLOG2_W), .MAX_LOG2(RING_MAX_LOG2)) u_len (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .log2_len (rlen_q[RLOG2_W*r +: RLOG2_W]),
      .len      (ring_len[r])
    );
  end
  assign rx_ring_len = ring_len[0];
  assign tx_ring_len = ring_len[1];

  // derived status
  logic              start, err_sum, int_flag;
  logic [WORD_W-1:0] ctrl_view;

  assign start    = ctrl_q[BIT_STRT];
  assign rx_on    = start & ~mode_q[MODE_NO_RX];
  assign tx_on    = start & ~mode_q[MODE_NO_TX];
  assign err_sum  = |ctrl_q[ERR_HI:ERR_LO];
  assign int_flag = |(ctrl_q[EVT_LSB+EVT_W-1:EVT_LSB] & ~mask_q[EVT_LSB+EVT_W-1:EVT_LSB]);
  assign irq      = int_flag & ctrl_q[BIT_IEN];

  always_comb begin
    ctrl_view           = ctrl_q & HELD_MASK;
    ctrl_view[BIT_ERR]  = err_sum;
    ctrl_view[BIT_FLAG] = int_flag;
    ctrl_view[BIT_RXON] = rx_on;
    ctrl_view[BIT_TXON] = tx_on;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_PTR: bus_rdata = {{(WORD_W-PTR_W){1'b0}}, ptr_q};
      SEL_BCR: bus_rdata = bcr_rd;
      SEL_CSR: begin
        if (is_ctrl)      bus_rdata = ctrl_view;
        else if (is_mask) bus_rdata = mask_q;
        else if (is_rlen) bus_rdata = {rlen_q, 8'h00};
        else if (is_mode) bus_rdata = mode_q;
        else              bus_rdata = csr_plain_rd;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_ptr |=> (ptr_q == $past(bus_wdata[PTR_W-1:0])));

  assert_mode_blocks_rx_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_csr && is_mode && bus_wdata[MODE_NO_RX]) |=> !rx_on);

  assert_enable_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_csr && is_ctrl && !bus_wdata[BIT_IEN]) |=> !irq);

  assert_full_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_csr && is_mask && (&bus_wdata[EVT_LSB+EVT_W-1:EVT_LSB])) |=> !irq);

  assert_err_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_csr && is_ctrl && !bus_wdata[BIT_STOP] && bus_wdata[BIT_ERR]
     && (bus_wdata[ERR_HI:ERR_LO] == '0) && (evt_set[EVT_W-1:ERR_LO-EVT_LSB] == '0))
    |=> (err_sum == $past(err_sum)));
endmodule

// File: tb/sim_ether_csr_frontend.sv
`timescale 1ns/1ps
module sim_ether_csr_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int BANK = 32;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [6:0]  evt_set;
  logic        irq, rx_on, tx_on, init_req, ring_clr;
  logic [9:0]  rx_ring_len, tx_ring_len;

  int vectors;
  int miscompares;
  bit done;

  ether_csr_frontend u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .irq(irq), .rx_on(rx_on), .tx_on(tx_on),
    .init_req(init_req), .ring_clr(ring_clr),
    .rx_ring_len(rx_ring_len), .tx_ring_len(tx_ring_len)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_rs1, m_rs2;
  int m_ptr, m_c0, m_mask, m_mode, m_c6, m_init, m_clr;
  int m_cb [BANK];
  int m_bb [BANK];

  function automatic void model_reset();
    m_ptr = 0; m_c0 = 'h0004; m_mask = 0; m_mode = 0; m_c6 = 0;
    m_init = 0; m_clr = 0;
    for (int i = 0; i < BANK; i++) begin m_cb[i] = 0; m_bb[i] = 0; end
  endfunction

  function automatic void model_step();
    int  d, e;
    bit  wr, ctrlw;
    d = int'(bus_wdata); e = int'(evt_set);
    wr = bus_en && bus_we;
    ctrlw = wr && bus_addr == 8'h10 && m_ptr == 0;
    m_init = 0; m_clr = 0;
    if (ctrlw && (d & 4) != 0) begin
      m_c0 = 'h0004; m_clr = 1;
    end else begin
      if (ctrlw) begin
        m_c0 = m_c0 & ~(d & 'h7F00);
        m_c0 = (m_c0 & ~'h40) | (d & 'h40);
        if ((d & 1) != 0) begin m_c0 = (m_c0 | 1) & ~4; m_init = 1; end
        if ((d & 2) != 0) m_c0 = (m_c0 | 2) & ~4;
      end
      m_c0 = m_c0 | (e << 8);
    end
    if (wr && bus_addr == 8'h10) begin
      case (m_ptr)
        0: ;
        3: m_mask = d;
        6: m_c6 = (d >> 8) & 'hFF;
        15: m_mode = d;
        default: if (m_ptr < BANK) m_cb[m_ptr] = d;
      endcase
    end
    if (wr && bus_addr == 8'h1C && m_ptr < BANK) m_bb[m_ptr] = d;
    if (wr && bus_addr == 8'h14) m_ptr = d & 'hFF;
  endfunction

  initial begin
    m_rs1 = 0; m_rs2 = 0;
    model_reset();
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_reset();
    end else begin
      if (m_rs2 == 0) model_reset(); else model_step();
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  function automatic int m_flag();
    return (((m_c0 & ~m_mask) >> 8) & 'h7F) != 0 ? 1 : 0;
  endfunction
  function automatic int m_rxon();
    return ((m_c0 & 2) != 0 && (m_mode & 1) == 0) ? 1 : 0;
  endfunction
  function automatic int m_txon();
    return ((m_c0 & 2) != 0 && (m_mode & 2) == 0) ? 1 : 0;
  endfunction
  function automatic int m_irq();
    return (m_flag() == 1 && (m_c0 & 'h40) != 0) ? 1 : 0;
  endfunction
  function automatic int m_len(int n);
    return n >= 9 ? 512 : (1 << n);
  endfunction
  function automatic int m_ctrl_view();
    int v;
    v = m_c0;
    if (((m_c0 >> 11) & 'hF) != 0) v = v | 'h8000;
    if (m_flag() == 1) v = v | 'h80;
    if (m_rxon() == 1) v = v | 'h20;
    if (m_txon() == 1) v = v | 'h10;
    return v;
  endfunction
  function automatic int m_read();
    case (bus_addr)
      8'h14: return m_ptr;
      8'h1C: return m_ptr < BANK ? m_bb[m_ptr] : 0;
      8'h10: begin
        case (m_ptr)
          0: return m_ctrl_view();
          3: return m_mask;
          6: return m_c6 << 8;
          15: return m_mode;
          default: return m_ptr < BANK ? m_cb[m_ptr] : 0;
        endcase
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R2 read data vs model", {16'h0, bus_rdata}, m_read());
      check("R9 irq vs model", {31'h0, irq}, m_irq());
      check("R8 rx_on vs model", {31'h0, rx_on}, m_rxon());
      check("R8 tx_on vs model", {31'h0, tx_on}, m_txon());
      check("R6 init_req vs model", {31'h0, init_req}, m_init);
      check("R3 ring_clr vs model", {31'h0, ring_clr}, m_clr);
      check("R11 rx_ring_len vs model", {22'h0, rx_ring_len}, m_len(m_c6 & 'hF));
      check("R11 tx_ring_len vs model", {22'h0, tx_ring_len}, m_len((m_c6 >> 4) & 'hF));
    end
  end

  // stimulus helpers
  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wr_evt(input logic [7:0] a, input logic [15:0] d, input logic [6:0] e);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_set = e;
    tick();
    bus_en = 1'b0; bus_we = 1'b0; evt_set = '0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_evt(a, d, 7'h00);
  endtask
  task automatic pulse(input logic [6:0] e);
    evt_set = e; tick(); evt_set = '0;
  endtask
  task automatic csr_wr(input logic [7:0] idx, input logic [15:0] d);
    wr(8'h14, {8'h00, idx}); wr(8'h10, d);
  endtask
  task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    check(tag, {16'h0, bus_rdata}, {16'h0, exp});
    tick();
    bus_en = 1'b0;
  endtask
  task automatic csr_rd(input string tag, input logic [7:0] idx, input logic [15:0] exp);
    wr(8'h14, {8'h00, idx}); rd(tag, 8'h10, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; evt_set = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // R12 reset state
    rd("R12 control word after reset", 8'h10, 16'h0004);
    check("R12 irq after reset", {31'h0, irq}, 0);
    check("R12 rx_on after reset", {31'h0, rx_on}, 0);
    check("R12 ring length after reset", {22'h0, rx_ring_len}, 1);
    rd("R12 pointer after reset", 8'h14, 16'h0000);

    // R1 pointer
    wr(8'h14, 16'h005A);
    rd("R1 pointer load", 8'h14, 16'h005A);
    wr(8'h14, 16'h1234);
    rd("R1 pointer keeps 8 bits", 8'h14, 16'h0034);
    rd("R2 unmapped offset reads 0", 8'h18, 16'h0000);

    // R2 banks
    csr_wr(8'd5, 16'h1234);
    csr_wr(8'd7, 16'hBEEF);
    csr_rd("R2 plain CSR readback", 8'd5, 16'h1234);
    wr(8'h14, 16'd5);
    rd("R2 config bank separate", 8'h1C, 16'h0000);
    wr(8'h1C, 16'h0F0F);
    rd("R2 config bank readback", 8'h1C, 16'h0F0F);
    rd("R2 CSR kept after config write", 8'h10, 16'h1234);
    csr_rd("R2 second plain CSR", 8'd7, 16'hBEEF);

    // R7, R8 start and mode
    csr_wr(8'd0, 16'h0002);
    csr_rd("R7 start sets enables", 8'd0, 16'h0032);
    csr_wr(8'd15, 16'h0001);
    csr_rd("R8 receive disabled", 8'd0, 16'h0012);
    check("R8 rx_on low", {31'h0, rx_on}, 0);
    check("R8 tx_on high", {31'h0, tx_on}, 1);
    csr_wr(8'd15, 16'h0003);
    csr_rd("R8 both disabled", 8'd0, 16'h0002);
    csr_wr(8'd15, 16'h0000);

    // R5 interrupt enable
    csr_wr(8'd0, 16'h0040);
    csr_rd("R5 enable written", 8'd0, 16'h0072);

    // R4, R9, R10 events, flag, error summary
    pulse(7'h04);
    csr_rd("R4 receive event sets bit 10", 8'd0, 16'h04F2);
    check("R9 irq asserted", {31'h0, irq}, 1);
    pulse(7'h08);
    csr_rd("R10 error summary set", 8'd0, 16'h8CF2);
    csr_wr(8'd3, 16'h0C00);
    csr_rd("R9 masked sources", 8'd0, 16'h8C72);
    check("R9 irq masked", {31'h0, irq}, 0);
    csr_wr(8'd3, 16'h0000);
    csr_wr(8'd0, 16'h0840);
    csr_rd("R4 clear memory error", 8'd0, 16'h04F2);
    csr_wr(8'd0, 16'h8040);
    csr_rd("R10 error bit read only", 8'd0, 16'h04F2);
    csr_wr(8'd0, 16'h0440);
    csr_rd("R4 clear receive interrupt", 8'd0, 16'h0072);
    check("R9 irq released", {31'h0, irq}, 0);
    wr(8'h14, 16'd0);
    wr_evt(8'h10, 16'h0240, 7'h02);
    csr_rd("R4 event beats clear", 8'd0, 16'h02F2);
    csr_wr(8'd0, 16'h0000);
    csr_rd("R5 enable cleared by write", 8'd0, 16'h02B2);
    check("R9 irq needs enable", {31'h0, irq}, 0);

    // R6 init
    csr_wr(8'd0, 16'h0001);
    check("R6 init pulse", {31'h0, init_req}, 1);
    tick();
    check("R6 init pulse one cycle", {31'h0, init_req}, 0);
    csr_rd("R6 init bit set", 8'd0, 16'h02B3);

    // R3 stop priority
    wr(8'h14, 16'd0);
    wr_evt(8'h10, 16'h0047, 7'h7F);
    check("R3 ring clear pulse", {31'h0, ring_clr}, 1);
    check("R3 init ignored", {31'h0, init_req}, 0);
    csr_rd("R3 stop word exact", 8'd0, 16'h0004);
    check("R3 rx_on off", {31'h0, rx_on}, 0);

    // R11 ring size word
    csr_wr(8'd6, 16'h3CFF);
    csr_rd("R11 fields read back", 8'd6, 16'h3C00);
    check("R11 receive capped", {22'h0, rx_ring_len}, 512);
    check("R11 transmit length", {22'h0, tx_ring_len}, 8);
    csr_wr(8'd6, 16'h9500);
    tick();
    check("R11 receive length", {22'h0, rx_ring_len}, 32);
    check("R11 transmit capped", {22'h0, tx_ring_len}, 512);
    csr_wr(8'd6, 16'h0000);
    tick();
    check("R11 length back to one", {22'h0, rx_ring_len}, 1);

    repeat (2) tick();
    finish_run();
  end
endmodule